// File: doc/BRIEF.md
# Four-Channel Byte DMA Controller

This block moves bytes between a peripheral and memory on an 8-bit processor bus with a 16-bit address space. While the processor owns the bus, the block acts as a slave. The processor uses an active-low select, read and write strobes, and a small register index to load each channel's 16-bit start address and 16-bit transfer word, one byte at a time. It writes a mode byte that enables channels and reads a status byte that reports terminal counts.

When an enabled channel has its request input high, the block raises a hold request. Once the processor grants the bus, the block becomes bus master and runs three-cycle transfers. In the first cycle it places the high address byte on the data pins with a strobe for an external latch, and it drives the low byte on dedicated pins. In the second and third cycles it drives the memory and I/O strobes that match the channel's operation. It pulses a terminal-count output on the final transfer of a block. It pulses a mark output whenever the remaining count is a multiple of 128.

Top module: `dmaEngine`

## Requirements
- R1: While and after reset, hrq, tc, mark, addrEn, addrStb and dataOe are low, all four bus strobes are high, and the status byte reads 0.
- R2: regSel[3]=0 selects channel regSel[2:1]: regSel[0]=0 is its address word and regSel[0]=1 is its transfer word. Every channel-register read or write moves the low byte if a shared byte pointer is 0 and the high byte if it is 1, then toggles the pointer. Reset clears the pointer to 0. regSel=4'b1000 writes the mode byte and reads the status byte.
- R3: hrq rises when a channel has both its enable and its request set. No DMA bus activity (addrEn, addrStb, strobes) starts until hlda is seen high while hrq is high.
- R4: In the first cycle of each transfer, addrStb=1, dataOe=1, dataOut carries address[15:8] and addrLo carries address[7:0]. addrEn stays high for all three cycles. The channel address increments by one after each transfer, carrying into the high byte.
- R5: Transfer word bits[15:14] select the cycle type. 2'b10 (read) drives memRdN and ioWrN low in cycles two and three. 2'b01 (write) drives ioRdN and memWrN low. 2'b00 and 2'b11 (verify) drive no strobe.
- R6: Transfer word bits[13:0] loaded with N-1 yield exactly N transfers, after which the count field reads 0 and the operation bits are unchanged.
- R7: tc is high in the third cycle of the final transfer only. That channel's status bit sets and its enable bit clears.
- R8: mark is high in the third cycle of a transfer whose remaining count, taken before the decrement, is 0 modulo 128.
- R9: When several enabled channels request at once, the lowest-numbered one is served first. dack is one-hot on the served channel during a transfer and 0 otherwise.
- R10: The status byte holds the terminal-count flags in bits[3:0] and the byte-pointer state in bit 4. A status read returns the flags and then clears them.
- R11: The status bit 4 update flag is 1 between the low-byte and high-byte access of a channel register, and reading status does not change it.
- R12: A request on a channel whose enable bit is 0 is ignored: hrq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Slave select, active low |
| wrN | input | 1 | Slave write strobe, active low, one cycle per access |
| rdN | input | 1 | Slave read strobe, active low, one cycle per access |
| regSel | input | 4 | Slave register index |
| dataIn | input | 8 | Data bus input |
| dataOut | output | 8 | Data bus output (read data or high address byte) |
| dataOe | output | 1 | Data bus output enable |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel transfer acknowledge |
| hrq | output | 1 | Bus hold request |
| hlda | input | 1 | Bus hold grant |
| addrLo | output | 8 | Low address byte |
| addrStb | output | 1 | High-byte latch strobe |
| addrEn | output | 1 | External address latch enable |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | Peripheral read strobe, active low |
| ioWrN | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Terminal count pulse |
| mark | output | 1 | Periodic block mark pulse |

## Verification
The bench sweeps every channel against every operation code with short blocks. Some start addresses sit just below a low-byte rollover, so a missing carry into the latched high byte shows as a wrong address on the next transfer. Long blocks of 130 and 257 transfers place marks both at the final transfer and at the multiples of 128 before it. A design that counted marks from the start of the block, or dropped the one at count zero, produces pulses at the wrong transfer indices. Holding the grant low while a request is pending catches a design that drives the bus before the handshake completes. Firing all four channels at once catches a wrong priority order or an enable bit that does not clear at terminal count, which shows up as a repeated transfer. Repeated status reads between byte writes catch a read that disturbs the update flag or fails to clear the terminal-count flags.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OP_W   = 2;
  localparam int CNT_W  = WORD_W - OP_W;
  localparam int SEL_W  = CH_W + 2;

  typedef enum logic [OP_W-1:0] {
    OP_VERIFY = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_RSVD   = 2'b11
  } opCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic            step;
    logic [CH_W-1:0] ch;
  } ctlStrb_t;
endpackage

// File: rtl/dmaRegs.sv
module dmaRegs import dmaPkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              slvWr,
  input  logic              slvRd,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  ctlStrb_t          strb,
  output logic [NUM_CH-1:0] chEn,
  output logic [WORD_W-1:0] curAddr,
  output logic [CNT_W-1:0]  curCnt,
  output opCode_e           curOp
);
  localparam logic [SEL_W-1:0] MISC_SEL = SEL_W'(1) << (SEL_W - 1);

  logic [NUM_CH-1:0][WORD_W-1:0] addrVec;
  logic [NUM_CH-1:0][WORD_W-1:0] cntVec;
  logic [NUM_CH-1:0]             tcFlag;
  logic                          byteHi;
  logic [CH_W-1:0]               accCh;
  logic                          chAccess, miscWr, miscRd, finalStep;
  logic [WORD_W-1:0]             rdWord;

  assign accCh     = regSel[CH_W:1];
  assign chAccess  = (slvWr || slvRd) && !regSel[SEL_W-1];
  assign miscWr    = slvWr && (regSel == MISC_SEL);
  assign miscRd    = slvRd && (regSel == MISC_SEL);
  assign finalStep = strb.step && (cntVec[strb.ch][CNT_W-1:0] == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic [WORD_W-1:0] addrQ, cntQ;
    logic stepMe, wrMe;
    assign stepMe = strb.step && (strb.ch == CH_W'(i));
    assign wrMe   = slvWr && !regSel[SEL_W-1] && (accCh == CH_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        addrQ <= '0;
        cntQ  <= '0;
      end else if (stepMe) begin
        addrQ <= addrQ + WORD_W'(1);
        if (cntQ[CNT_W-1:0] != '0)
          cntQ[CNT_W-1:0] <= cntQ[CNT_W-1:0] - CNT_W'(1);
      end else if (wrMe) begin
        if (regSel[0]) begin
          if (byteHi) cntQ[WORD_W-1:BYTE_W] <= wrData;
          else        cntQ[BYTE_W-1:0]      <= wrData;
        end else begin
          if (byteHi) addrQ[WORD_W-1:BYTE_W] <= wrData;
          else        addrQ[BYTE_W-1:0]      <= wrData;
        end
      end
    end
    assign addrVec[i] = addrQ;
    assign cntVec[i]  = cntQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chEn   <= '0;
      tcFlag <= '0;
      byteHi <= 1'b0;
    end else begin
      if (chAccess) byteHi <= !byteHi;
      if (miscWr)   chEn   <= wrData[NUM_CH-1:0];
      if (miscRd)   tcFlag <= '0;
      if (finalStep) begin
        tcFlag[strb.ch] <= 1'b1;
        chEn[strb.ch]   <= 1'b0;
      end
    end
  end

  assign rdWord = regSel[0] ? cntVec[accCh] : addrVec[accCh];

  always_comb begin
    if (regSel[SEL_W-1])
      rdData = (regSel == MISC_SEL) ? BYTE_W'({byteHi, tcFlag}) : '0;
    else
      rdData = byteHi ? rdWord[WORD_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
  end

  assign curAddr = addrVec[strb.ch];
  assign curCnt  = cntVec[strb.ch][CNT_W-1:0];
  assign curOp   = opCode_e'(cntVec[strb.ch][WORD_W-1:CNT_W]);
endmodule

// File: rtl/dmaSeq.sv
module dmaSeq import dmaPkg::*; #(
  parameter int MARK_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [NUM_CH-1:0] chEn,
  input  logic              hlda,
  input  logic [CNT_W-1:0]  curCnt,
  input  opCode_e           curOp,
  output ctlStrb_t          strb,
  output logic              hrq,
  output logic              busOwn,
  output logic              addrStb,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              tc,
  output logic              mark,
  output logic [NUM_CH-1:0] dack
);
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_ADDR, ST_XFER, ST_LAST} state_e;

  state_e            state, nextState;
  logic [NUM_CH-1:0] pending;
  logic              anyPend, strobing;
  logic [CH_W-1:0]   winner, chSel;

  assign pending = dreq & chEn;
  assign anyPend = |pending;

  always_comb begin
    winner = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pending[i]) winner = CH_W'(i);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (anyPend) nextState = ST_HOLD;
      ST_HOLD: begin
        if (!anyPend)  nextState = ST_IDLE;
        else if (hlda) nextState = ST_ADDR;
      end
      ST_ADDR: nextState = ST_XFER;
      ST_XFER: nextState = ST_LAST;
      ST_LAST: nextState = ST_HOLD;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      chSel <= '0;
    end else begin
      state <= nextState;
      if (state == ST_HOLD && anyPend && hlda) chSel <= winner;
    end
  end

  assign hrq      = (state != ST_IDLE);
  assign busOwn   = (state == ST_ADDR) || strobing;
  assign strobing = (state == ST_XFER) || (state == ST_LAST);
  assign addrStb  = (state == ST_ADDR);

  assign memRdN = !(strobing && curOp == OP_READ);
  assign ioWrN  = !(strobing && curOp == OP_READ);
  assign ioRdN  = !(strobing && curOp == OP_WRITE);
  assign memWrN = !(strobing && curOp == OP_WRITE);

  assign tc   = (state == ST_LAST) && (curCnt == '0);
  assign mark = (state == ST_LAST) && (curCnt[MARK_LOG2-1:0] == '0);

  assign strb.step = (state == ST_LAST);
  assign strb.ch   = chSel;

  always_comb begin
    dack = '0;
    if (busOwn) dack[chSel] = 1'b1;
  end
endmodule

// File: rtl/dmaEngine.sv
module dmaEngine import dmaPkg::*; #(
  parameter int MARK_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [NUM_CH-1:0] dreq,
  output logic [NUM_CH-1:0] dack,
  output logic              hrq,
  input  logic              hlda,
  output logic [BYTE_W-1:0] addrLo,
  output logic              addrStb,
  output logic              addrEn,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              tc,
  output logic              mark
);
  ctlStrb_t          strb;
  logic              busOwn, slvWr, slvRd;
  logic [BYTE_W-1:0] rdData;
  logic [NUM_CH-1:0] chEn;
  logic [WORD_W-1:0] curAddr;
  logic [CNT_W-1:0]  curCnt;
  opCode_e           curOp;

  assign slvWr = !csN && !wrN && !busOwn;
  assign slvRd = !csN && !rdN && !busOwn;

  dmaRegs uRegs (
    .clk(clk), .rst(rst), .slvWr(slvWr), .slvRd(slvRd), .regSel(regSel),
    .wrData(dataIn), .rdData(rdData), .strb(strb), .chEn(chEn),
    .curAddr(curAddr), .curCnt(curCnt), .curOp(curOp)
  );

  dmaSeq #(.MARK_LOG2(MARK_LOG2)) uSeq (
    .clk(clk), .rst(rst), .dreq(dreq), .chEn(chEn), .hlda(hlda),
    .curCnt(curCnt), .curOp(curOp), .strb(strb), .hrq(hrq), .busOwn(busOwn),
    .addrStb(addrStb), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
    .ioWrN(ioWrN), .tc(tc), .mark(mark), .dack(dack)
  );

  assign addrEn  = busOwn;
  assign addrLo  = busOwn ? curAddr[BYTE_W-1:0] : '0;
  assign dataOe  = addrStb || slvRd;
  assign dataOut = addrStb ? curAddr[WORD_W-1:BYTE_W] : (slvRd ? rdData : '0);
endmodule

// File: rtl/dmaEngineChk.sv
module dmaEngineChk import dmaPkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              hlda,
  input logic              hrq,
  input logic              addrStb,
  input logic              addrEn,
  input logic              dataOe,
  input logic              memRdN,
  input logic              memWrN,
  input logic              ioRdN,
  input logic              ioWrN,
  input logic              tc,
  input logic [NUM_CH-1:0] dack
);
  AST_STROBE_NEEDS_OWNERSHIP: assert property (@(posedge clk) disable iff (rst)
    (!memRdN || !memWrN || !ioRdN || !ioWrN || addrStb) |-> addrEn); // R3
  AST_OWNERSHIP_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(addrEn) |-> $past(hlda)); // R3
  AST_HOLD_WHILE_OWNED: assert property (@(posedge clk) disable iff (rst)
    addrEn |-> hrq); // R3
  AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    addrStb |=> !addrStb); // R4
  AST_LATCH_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    addrStb |-> dataOe); // R4
  AST_NO_MEM_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    !(!memRdN && !memWrN)); // R5
  AST_TC_IN_STROBE_PHASE: assert property (@(posedge clk) disable iff (rst)
    tc |-> (addrEn && !addrStb)); // R7
  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack)); // R9
endmodule

bind dmaEngine dmaEngineChk uChk (
  .clk(clk), .rst(rst), .hlda(hlda), .hrq(hrq), .addrStb(addrStb),
  .addrEn(addrEn), .dataOe(dataOe), .memRdN(memRdN), .memWrN(memWrN),
  .ioRdN(ioRdN), .ioWrN(ioWrN), .tc(tc), .dack(dack)
);

// File: tb/sim_dmaEngine.sv
module sim_dmaEngine;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] STAT_SEL = 4'b1000;

  logic clk = 1'b0, rst = 1'b1;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic [3:0] regSel = '0;
  logic [7:0] dataIn = '0, dataOut, addrLo;
  logic dataOe, hrq, hlda = 1'b0, addrStb, addrEn, memRdN, memWrN, ioRdN, ioWrN, tc, mark;
  logic [3:0] dreq = '0, dack;
  bit hldaAllow = 1'b1;
  bit finished = 1'b0;
  int nChecks = 0, nFails = 0;

  dmaEngine u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    hlda <= hrq && hldaAllow;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; regSel = sel; dataIn = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic regRd(input logic [3:0] sel, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; regSel = sel;
    #1 d = dataOut;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  function automatic int expStr(input int op);
    if (op == 2) return 4'b0110;
    if (op == 1) return 4'b1001;
    return 4'b1111;
  endfunction

  task automatic loadChan(input int ch, input logic [15:0] addr, input int op, input int n);
    logic [15:0] w;
    w = {op[1:0], 14'(n - 1)};
    regWr({1'b0, ch[1:0], 1'b0}, addr[7:0]);
    regWr({1'b0, ch[1:0], 1'b0}, addr[15:8]);
    regWr({1'b0, ch[1:0], 1'b1}, w[7:0]);
    regWr({1'b0, ch[1:0], 1'b1}, w[15:8]);
  endtask

  task automatic observeXfer(input int ch, input logic [15:0] addr, input int op,
                             input bit lastX, input bit markX);
    int guard = 0;
    while (addrStb !== 1'b1 && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    chk("R3 transfer start", int'(addrStb), 1);
    chk("R4 latched address", int'({dataOut, addrLo}), int'(addr));
    chk("R4 dataOe in address cycle", int'(dataOe), 1);
    chk("R9 dack", int'(dack), 1 << ch);
    @(negedge clk);
    chk("R5 strobes cycle two", int'({memRdN, memWrN, ioRdN, ioWrN}), expStr(op));
    chk("R4 addrEn held", int'(addrEn), 1);
    @(negedge clk);
    chk("R5 strobes cycle three", int'({memRdN, memWrN, ioRdN, ioWrN}), expStr(op));
    chk("R7 tc", int'(tc), int'(lastX));
    chk("R8 mark", int'(mark), int'(markX));
  endtask

  task automatic finishBlock(input int ch, input logic [15:0] endAddr, input int op);
    logic [7:0] d;
    int guard = 0;
    while (hrq && guard < 10) begin
      @(negedge clk);
      guard++;
      chk("R6 no extra transfer", int'(addrStb), 0);
    end
    dreq = '0;
    regRd(STAT_SEL, d);
    chk("R10 status tc flag", int'(d), 1 << ch);
    regRd(STAT_SEL, d);
    chk("R10 status cleared by read", int'(d), 0);
    regRd({1'b0, ch[1:0], 1'b0}, d);
    chk("R4 final address low", int'(d), int'(endAddr[7:0]));
    regRd({1'b0, ch[1:0], 1'b0}, d);
    chk("R4 final address high", int'(d), int'(endAddr[15:8]));
    regRd({1'b0, ch[1:0], 1'b1}, d);
    chk("R6 count low after block", int'(d), 0);
    regRd({1'b0, ch[1:0], 1'b1}, d);
    chk("R6 opcode kept", int'(d), op << 6);
    @(negedge clk);
    dreq[ch] = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R7 enable cleared at tc", int'(hrq), 0);
    end
    dreq = '0;
  endtask

  task automatic runBlock(input int ch, input int n, input int op, input logic [15:0] base);
    loadChan(ch, base, op, n);
    regWr(STAT_SEL, 8'(1 << ch));
    @(negedge clk);
    dreq[ch] = 1'b1;
    for (int k = 0; k < n; k++)
      observeXfer(ch, base + 16'(k), op, k == n - 1, ((n - 1 - k) % 128) == 0);
    finishBlock(ch, base + 16'(n), op);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 hrq", int'(hrq), 0);
    chk("R1 strobes", int'({memRdN, memWrN, ioRdN, ioWrN}), 4'b1111);
    chk("R1 addrEn/addrStb/dataOe/tc/mark", int'({addrEn, addrStb, dataOe, tc, mark}), 0);
    regRd(STAT_SEL, d);
    chk("R1 status", int'(d), 0);

    // R11 update flag around a split access, R2 byte readback
    regWr(4'b0000, 8'h34);
    regRd(STAT_SEL, d);
    chk("R11 update flag after low byte", int'(d), 8'h10);
    regRd(STAT_SEL, d);
    chk("R11 update flag kept by status read", int'(d), 8'h10);
    regWr(4'b0000, 8'h12);
    regRd(STAT_SEL, d);
    chk("R11 update flag after high byte", int'(d), 0);
    regRd(4'b0000, d);
    chk("R2 readback low", int'(d), 8'h34);
    regRd(4'b0000, d);
    chk("R2 readback high", int'(d), 8'h12);

    // R12 request on disabled channel
    @(negedge clk);
    dreq = 4'b0001;
    repeat (8) begin
      @(negedge clk);
      chk("R12 disabled request ignored", int'(hrq), 0);
    end
    dreq = '0;

    // R3 no bus activity until grant; carry across high byte
    loadChan(1, 16'h1FFE, 2, 3);
    regWr(STAT_SEL, 8'h02);
    hldaAllow = 1'b0;
    @(negedge clk);
    dreq[1] = 1'b1;
    @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      chk("R3 hrq raised", int'(hrq), 1);
      chk("R3 idle bus before grant", int'({addrEn, addrStb, memRdN, ioWrN}), 4'b0011);
    end
    hldaAllow = 1'b1;
    for (int k = 0; k < 3; k++)
      observeXfer(1, 16'h1FFE + 16'(k), 2, k == 2, k == 2);
    finishBlock(1, 16'h2001, 2);

    // sweep of channels, operations and lengths
    for (int ch = 0; ch < 4; ch++)
      for (int op = 0; op < 4; op++)
        runBlock(ch, 1 + (ch + op) % 3, op, 16'(ch * 16'h1000 + op * 16'h40 + 16'hFE));

    // R8 long blocks with interior marks
    runBlock(2, 130, 0, 16'h8000);
    runBlock(3, 257, 1, 16'hC0F0);

    // R9 simultaneous requests resolved lowest first
    for (int ch = 0; ch < 4; ch++) loadChan(ch, 16'(16'h0100 * (ch + 1)), 2, 1);
    regWr(STAT_SEL, 8'h0F);
    @(negedge clk);
    dreq = 4'b1111;
    for (int ch = 0; ch < 4; ch++)
      observeXfer(ch, 16'(16'h0100 * (ch + 1)), 2, 1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R9 all channels served", int'(hrq), 0);
    dreq = '0;
    regRd(STAT_SEL, d);
    chk("R10 all tc flags", int'(d), 8'h0F);
    regRd(STAT_SEL, d);
    chk("R10 flags cleared", int'(d), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule